// File: doc/BRIEF.md
# Replayable Burst-Fill Element Stream Buffer

This block is a first-level vector buffer that sits between a wide memory bus and an array of processing elements. Whole bus words are written into it in bursts. It then hands them out one narrow element per clock cycle, in exactly the order they arrived. Inside each word, the least significant element comes out first.

Reading does not consume storage. A replay pulse moves the read position back to the oldest stored word, and the same contents can then be streamed out again without being rewritten. This lets a fixed set of vectors be matched against many other vectors. A flush pulse discards everything, so the buffer can take a fresh set of data.

The write side has a valid strobe only. The read side uses a ready/valid handshake. Status outputs report full, empty, and a sticky overflow condition.

Top module: `replay_stream_buf`

## Requirements
- R1: After reset, `empty` is 1, and `full`, `overflow` and `rd_valid` are 0.
- R2: A word written with `wr_valid` while the buffer is not full can be read starting in the next cycle, and `rd_valid` is the inverse of `empty`.
- R3: Each stored word of WORD_W bits yields WORD_W/ELEM_W elements, one per cycle in which `rd_valid` and `rd_ready` are both 1. Element k is bits [k*ELEM_W +: ELEM_W], starting from k = 0. Words are read in the order they were written.
- R4: While `rd_valid` is 1 and `rd_ready` is 0, and neither `replay` nor `flush` is asserted, `rd_data` and `rd_valid` hold their values into the next cycle.
- R5: `empty` rises once every stored element has been read. Reading frees no space, and `full` still depends only on how many words have been written since the last flush.
- R6: `full` is 1 when the number of stored words equals DEPTH. A write while full is dropped: the stored contents and the count do not change.
- R7: A write attempted while full sets `overflow`. `overflow` stays at 1 until a flush or reset.
- R8: After a `replay` pulse, the next element is element 0 of the oldest stored word, and the full stored sequence streams again. The stored word count does not change. If `replay` and a read handshake occur in the same cycle, the replay wins.
- R9: A `flush` pulse empties the buffer and clears `full` and `overflow`. A write or replay in the same cycle is overridden, and the dropped write leaves nothing behind.
- R10: A write accepted while a word is partly read appends after the stored words and does not disturb the element stream in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | Write strobe for one bus word |
| wr_data | input | WORD_W | Bus word to store |
| rd_ready | input | 1 | Consumer accepts the current element |
| rd_valid | output | 1 | An element is available on `rd_data` |
| rd_data | output | ELEM_W | Current element |
| replay | input | 1 | Restart streaming from the oldest stored word |
| flush | input | 1 | Discard all stored words |
| full | output | 1 | Stored words equal DEPTH |
| empty | output | 1 | All stored elements have been read |
| overflow | output | 1 | Sticky flag: a write was dropped while full |

## Verification
A wrong element index or word pointer shows up on `rd_data` at the very next handshake as a byte from the wrong lane or the wrong word. Because every byte the bench writes is a distinct arithmetic function of word, lane and seed, a single misplaced element is caught in the cycle it appears. A wrong stored count shows up as `full` asserting one write early or late, or as `rd_valid` staying high past the last written word. A replay or flush that leaves the read position stale gives the wrong first byte on the cycle after the pulse. Sweeps over several consumer stall patterns make sure a stalled handshake never advances or corrupts the stream.

// File: rtl/rsb_pkg.sv
// Shared definitions for the replayable stream buffer.
// Assumes: nothing beyond IEEE 1800-2017.
package rsb_pkg;

    // Read-position update chosen each cycle by the reader.
    typedef enum logic [1:0] {
        PTR_HOLD   = 2'd0,
        PTR_STEP   = 2'd1,
        PTR_REWIND = 2'd2
    } ptr_op_e;

endpackage

// File: rtl/rsb_store.sv
// Word storage, write counter, full and overflow tracking.
// Does: stores bus words in arrival order starting at slot 0 after a flush,
//       and exposes one word picked by the reader.
// Assumes: DEPTH >= 2; reads never free space, only flush does.
module rsb_store #(
    parameter int WORD_W = 256,
    parameter int DEPTH  = 8,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              flush,
    input  logic [CNT_W-1:0]  rd_word_idx,
    output logic [WORD_W-1:0] rd_word,
    output logic [CNT_W-1:0]  word_cnt,
    output logic              full,
    output logic              overflow
);

    logic [WORD_W-1:0] mem [DEPTH];
    logic              accept;

    assign full    = (word_cnt == CNT_W'(DEPTH));
    assign accept  = wr_valid && !full && !flush;
    assign rd_word = mem[rd_word_idx[AW-1:0]];

    // Store an accepted word in the next free slot.
    always_ff @(posedge clk) begin
        if (accept) begin
            mem[word_cnt[AW-1:0]] <= wr_data;
        end
    end

    // Count stored words; flush returns to zero.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            word_cnt <= '0;
        end else if (accept) begin
            word_cnt <= word_cnt + CNT_W'(1);
        end
    end

    // Sticky record of a write dropped while full.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            overflow <= 1'b0;
        end else if (wr_valid && full) begin
            overflow <= 1'b1;
        end
    end

    assert_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        word_cnt <= CNT_W'(DEPTH));
    assert_full_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        full && !flush |=> $stable(word_cnt));
    assert_ovf_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && full && !flush |=> overflow);
    assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        overflow && !flush |=> overflow);
    assert_flush_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (word_cnt == '0) && !overflow);

endmodule

// File: rtl/rsb_reader.sv
// Read position: word index plus element index inside the word.
// Does: steps one element per handshake, rewinds on replay or flush.
// Assumes: ELEMS >= 2; word_cnt only grows except on flush.
module rsb_reader
    import rsb_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int ELEMS  = 32,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int EW    = $clog2(ELEMS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] word_cnt,
    input  logic             rd_ready,
    input  logic             replay,
    input  logic             flush,
    output logic [CNT_W-1:0] word_idx,
    output logic [EW-1:0]    elem_idx,
    output logic             rd_valid
);

    ptr_op_e op;
    logic    last_elem;

    assign rd_valid  = (word_idx != word_cnt);
    assign last_elem = (elem_idx == EW'(ELEMS - 1));

    // Pick the pointer action; rewind outranks a handshake.
    always_comb begin
        if (flush || replay) begin
            op = PTR_REWIND;
        end else if (rd_valid && rd_ready) begin
            op = PTR_STEP;
        end else begin
            op = PTR_HOLD;
        end
    end

    // Apply the pointer action.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_idx <= '0;
            elem_idx <= '0;
        end else begin
            case (op)
                PTR_REWIND: begin
                    word_idx <= '0;
                    elem_idx <= '0;
                end
                PTR_STEP: begin
                    if (last_elem) begin
                        elem_idx <= '0;
                        word_idx <= word_idx + CNT_W'(1);
                    end else begin
                        elem_idx <= elem_idx + EW'(1);
                    end
                end
                default: begin
                    word_idx <= word_idx;
                    elem_idx <= elem_idx;
                end
            endcase
        end
    end

    assert_rewind_R8: assert property (@(posedge clk) disable iff (!rst_n)
        replay || flush |=> (word_idx == '0) && (elem_idx == '0));
    assert_no_overrun_R5: assert property (@(posedge clk) disable iff (!rst_n)
        word_idx <= word_cnt);
    assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && rd_ready && !replay && !flush && !last_elem
        |=> (elem_idx == $past(elem_idx) + EW'(1)) && $stable(word_idx));

endmodule

// File: rtl/replay_stream_buf.sv
// Top of the replayable burst-fill element stream buffer.
// Does: joins word storage and read position, and splits the selected word
//       into element lanes, emitting the lowest lane first.
// Assumes: WORD_W is a multiple of ELEM_W with at least two lanes.
module replay_stream_buf #(
    parameter int WORD_W = 256,
    parameter int ELEM_W = 8,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_ready,
    output logic              rd_valid,
    output logic [ELEM_W-1:0] rd_data,
    input  logic              replay,
    input  logic              flush,
    output logic              full,
    output logic              empty,
    output logic              overflow
);

    localparam int ELEMS = WORD_W / ELEM_W;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int EW    = $clog2(ELEMS);

    logic [CNT_W-1:0]  word_cnt;
    logic [CNT_W-1:0]  word_idx;
    logic [EW-1:0]     elem_idx;
    logic [WORD_W-1:0] cur_word;
    logic [ELEM_W-1:0] lanes [ELEMS];

    rsb_store #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
        .flush(flush), .rd_word_idx(word_idx), .rd_word(cur_word),
        .word_cnt(word_cnt), .full(full), .overflow(overflow)
    );

    rsb_reader #(.DEPTH(DEPTH), .ELEMS(ELEMS)) u_reader (
        .clk(clk), .rst_n(rst_n), .word_cnt(word_cnt), .rd_ready(rd_ready),
        .replay(replay), .flush(flush), .word_idx(word_idx),
        .elem_idx(elem_idx), .rd_valid(rd_valid)
    );

    // Split the current word into element lanes, lane 0 at the low bits.
    for (genvar g = 0; g < ELEMS; g++) begin : g_lane
        assign lanes[g] = cur_word[g*ELEM_W +: ELEM_W];
    end

    assign rd_data = lanes[elem_idx];
    assign empty   = !rd_valid;

    assert_stall_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && !rd_ready && !replay && !flush
        |=> rd_valid && $stable(rd_data));
    assert_full_not_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        full && !flush && !replay && !rd_ready |=> full);

endmodule

// File: tb/replay_stream_buf_bench.sv
module replay_stream_buf_bench;

    localparam int WORD_W = 256;
    localparam int ELEM_W = 8;
    localparam int DEPTH  = 8;
    localparam int ELEMS  = WORD_W / ELEM_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_valid = 1'b0;
    logic [WORD_W-1:0] wr_data = '0;
    logic              rd_ready = 1'b0;
    logic              rd_valid;
    logic [ELEM_W-1:0] rd_data;
    logic              replay = 1'b0;
    logic              flush = 1'b0;
    logic              full, empty, overflow;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [7:0] seed_of [DEPTH];

    always #10 clk = ~clk;

    replay_stream_buf #(.WORD_W(WORD_W), .ELEM_W(ELEM_W), .DEPTH(DEPTH)) u_replay_stream_buf (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
        .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_data(rd_data),
        .replay(replay), .flush(flush), .full(full), .empty(empty),
        .overflow(overflow)
    );

    function automatic logic [7:0] exp_byte(input int w, input int e, input logic [7:0] s);
        return 8'((w * 37 + e * 11 + int'(s)) % 256);
    endfunction

    function automatic logic [WORD_W-1:0] mk_word(input int w, input logic [7:0] s);
        logic [WORD_W-1:0] v = '0;
        for (int e = 0; e < ELEMS; e++) v[e*ELEM_W +: ELEM_W] = exp_byte(w, e, s);
        return v;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic put_word(input int w, input logic [7:0] s, input bit keep);
        if (keep) seed_of[w] = s;
        @(negedge clk);
        wr_valid = 1'b1;
        wr_data  = mk_word(w, s);
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic take(input int w, input int e, input string req);
        logic [7:0] x = exp_byte(w, e, seed_of[w]);
        @(negedge clk);
        chk(rd_valid && rd_data == x, req, {rd_valid, rd_data}, {1'b1, x});
        rd_ready = 1'b1;
        @(posedge clk);
        #1 rd_ready = 1'b0;
    endtask

    task automatic take_word(input int w, input string req);
        for (int e = 0; e < ELEMS; e++) take(w, e, req);
    endtask

    task automatic stall(input int n, input int w, input int e, input string req);
        logic [7:0] x = exp_byte(w, e, seed_of[w]);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(rd_valid && rd_data == x, req, {rd_valid, rd_data}, {1'b1, x});
        end
    endtask

    task automatic pulse_flush();
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk(empty && !full && !overflow && !rd_valid, "R1",
            {empty, full, overflow, rd_valid}, 4'b1000);

        // R2 availability next cycle, R3 lane order
        put_word(0, 8'h11, 1'b1);
        chk(rd_valid && !empty, "R2", {rd_valid, empty}, 2'b10);
        take_word(0, "R3");
        @(negedge clk);
        chk(empty && !rd_valid && !full, "R5", {empty, rd_valid, full}, 3'b100);

        // Fill to depth; reads freed nothing (R5, R6)
        for (int w = 1; w < DEPTH; w++) begin
            chk(!full, "R6", full, 0);
            put_word(w, 8'(8'h20 + w * 3), 1'b1);
        end
        chk(full && rd_valid, "R5", {full, rd_valid}, 2'b11);

        // R4 stall then partial read
        stall(3, 1, 0, "R4");
        for (int e = 0; e < 10; e++) take(1, e, "R3");
        stall(2, 1, 10, "R4");

        // R7 overflow on dropped write
        put_word(8, 8'hEE, 1'b0);
        chk(overflow && full, "R7", {overflow, full}, 2'b11);
        for (int e = 10; e < ELEMS; e++) take(1, e, "R6");
        for (int w = 2; w < DEPTH; w++) take_word(w, "R6");
        @(negedge clk);
        chk(empty, "R6", empty, 1);

        // R8 replay restores the stream; count and overflow kept
        @(negedge clk); replay = 1'b1;
        @(negedge clk); replay = 1'b0;
        chk(overflow && full && rd_valid, "R8", {overflow, full, rd_valid}, 3'b111);
        for (int e = 0; e < 5; e++) take(0, e, "R8");
        @(negedge clk); replay = 1'b1; rd_ready = 1'b1;
        @(negedge clk); replay = 1'b0; rd_ready = 1'b0;
        for (int w = 0; w < DEPTH; w++) take_word(w, "R8");
        @(negedge clk);
        chk(empty && overflow, "R7", {empty, overflow}, 2'b11);

        // R9 flush beats simultaneous write and replay
        @(negedge clk);
        flush = 1'b1; replay = 1'b1; wr_valid = 1'b1; wr_data = mk_word(5, 8'h77);
        @(negedge clk);
        flush = 1'b0; replay = 1'b0; wr_valid = 1'b0;
        chk(empty && !full && !overflow && !rd_valid, "R9",
            {empty, full, overflow, rd_valid}, 4'b1000);
        @(negedge clk);
        chk(!rd_valid, "R9", rd_valid, 0);

        // R10 append during a partly read word
        put_word(0, 8'h5A, 1'b1);
        for (int e = 0; e < 16; e++) take(0, e, "R10");
        seed_of[1] = 8'hC3;
        @(negedge clk);
        chk(rd_valid && rd_data == exp_byte(0, 16, seed_of[0]), "R10",
            rd_data, exp_byte(0, 16, seed_of[0]));
        wr_valid = 1'b1; wr_data = mk_word(1, 8'hC3); rd_ready = 1'b1;
        @(posedge clk);
        #1 wr_valid = 1'b0; rd_ready = 1'b0;
        for (int e = 17; e < ELEMS; e++) take(0, e, "R10");
        take_word(1, "R10");

        // Sweep consumer stall patterns (R3, R4)
        for (int k = 1; k <= 4; k++) begin
            pulse_flush();
            for (int w = 0; w < 3; w++) put_word(w, 8'(k * 50 + w * 7), 1'b1);
            for (int w = 0; w < 3; w++) begin
                for (int e = 0; e < ELEMS; e++) begin
                    if ((e % k) != 0) stall(k - 1, w, e, "R4");
                    take(w, e, "R3");
                end
            end
            @(negedge clk);
            chk(empty, "R5", empty, 1);
        end

        finish_run();
    end

endmodule